// File: doc/BRIEF.md
# Vendor Message Capture Unit

This block sits on the inbound message path of a PCI Express endpoint. Each valid beat on its input carries one complete four-DW message header. The block looks for vendor-defined messages of both kinds, Type 0 and Type 1. When it finds one and is free to take it, it latches the whole header into a bank of read-only registers and raises a sticky "message received" flag. Software reads the header and then clears the flag by writing a one.

While the flag is set, further vendor messages are not consumed. The block lowers its ready output so that the message stays upstream until software clears the flag. A mask input changes this behaviour. With the mask set, nothing is captured: a Type 0 message is turned into an unsupported-request pulse that carries the sender's Requester ID and Tag, and a Type 1 message is dropped without any trace. Beats that are not vendor messages are always accepted and have no effect on the block.

Top module: `vmsg_capture`

## Requirements
- R1: An accepted vendor message with the mask clear is latched whole into `hdr_regs_o`. Header DW n is taken from `in_hdr[n*32 +: 32]` and appears at `hdr_regs_o[n*32 +: 32]` one clock after the accepting edge. No port can write the registers.
- R2: The byte order within each DW is kept. Header byte 4n+0 sits in bits 31:24 of DW n, byte 4n+1 in bits 23:16, byte 4n+2 in bits 15:8 and byte 4n+3 in bits 7:0.
- R3: After a synchronous reset, all header register bits, `rcvd_o` and `ur_valid_o` are 0, and `in_ready` is 1.
- R4: A beat is a vendor message only when DW0 bits 28:27 equal 2'b10 (the message type group) and the Message Code in DW1 bits 7:0 is 0x7E (Type 0) or 0x7F (Type 1). Every other beat is accepted and has no effect on the header registers, `rcvd_o` or `ur_valid_o`.
- R5: `rcvd_o` rises on the clock after a vendor message is captured.
- R6: While `rcvd_o` is 1 and `mask_i` is 0, `in_ready` is 0 whenever a vendor message is presented, so the message is held. Non-vendor beats are still accepted.
- R7: When `mask_i` is 1, an accepted Type 0 message is not captured. On the next clock `ur_valid_o` pulses for exactly one cycle, with `ur_req_id_o` set to DW1 bits 31:16 and `ur_tag_o` set to DW1 bits 15:8.
- R8: When `mask_i` is 1, an accepted Type 1 message is discarded: no capture, no change to `rcvd_o`, and no unsupported-request pulse.
- R9: Asserting `sts_clr_i` for one cycle clears `rcvd_o` on the next clock. If a capture happens in the same cycle, `rcvd_o` stays 1 and the new header is kept.
- R10: Raising `mask_i` while a vendor message is held raises `in_ready` in that same cycle. The released message is then handled under R7 or R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A header beat is present |
| in_ready | output | 1 | The block takes the beat at this edge |
| in_hdr | input | NUM_DW*32 | Message header, DW n in bits n*32+31 : n*32 |
| mask_i | input | 1 | Vendor message mask |
| sts_clr_i | input | 1 | Write-one-to-clear strobe for the received flag |
| rcvd_o | output | 1 | Sticky vendor message received flag |
| hdr_regs_o | output | NUM_DW*32 | Captured header, read-only |
| ur_valid_o | output | 1 | One-cycle unsupported-request indication |
| ur_req_id_o | output | 16 | Requester ID of the rejected message |
| ur_tag_o | output | 8 | Tag of the rejected message |

## Verification
The bench builds the block with its default parameters: four header DWs and Message Codes 0x7E and 0x7F. With these values every disposal path can be reached through directed beats: capture, hold under back-pressure, release when software clears the flag, release when the mask is raised, unsupported-request reporting, and silent discard. Near-miss headers (a right code with a wrong type group, or a right type group with a neighbouring code) exercise the classification edges. A clear strobe that arrives in the same cycle as a capture exercises the precedence rule.

// File: rtl/vmsg_pkg.sv
package vmsg_pkg;

    localparam int DW_W    = 32;
    localparam int RID_W   = 16;
    localparam int TAG_W   = 8;
    localparam int CODE_W  = 8;

    typedef enum logic [1:0] {
        VK_OTHER = 2'd0,
        VK_T0    = 2'd1,
        VK_T1    = 2'd2
    } vkind_e;

    typedef struct packed {
        logic [RID_W-1:0] req_id;
        logic [TAG_W-1:0] tag;
    } ur_info_t;

    // Fmt/Type byte is bits 31:24 of DW0; type group lives in Type[4:3]
    function automatic logic is_msg_group(input logic [DW_W-1:0] dw0);
        return dw0[28:27] == 2'b10;
    endfunction

    function automatic vkind_e decode_kind(input logic [DW_W-1:0] dw0,
                                           input logic [DW_W-1:0] dw1,
                                           input logic [CODE_W-1:0] code_t0,
                                           input logic [CODE_W-1:0] code_t1);
        vkind_e k;
        k = VK_OTHER;
        if (is_msg_group(dw0)) begin
            if (dw1[CODE_W-1:0] == code_t0)      k = VK_T0;
            else if (dw1[CODE_W-1:0] == code_t1) k = VK_T1;
        end
        return k;
    endfunction

endpackage

// File: rtl/vmsg_classify.sv
module vmsg_classify
    import vmsg_pkg::*;
#(
    parameter int                 NUM_DW  = 4,
    parameter logic [CODE_W-1:0]  CODE_T0 = 8'h7E,
    parameter logic [CODE_W-1:0]  CODE_T1 = 8'h7F,
    localparam int                HDR_W   = NUM_DW * DW_W
) (
    input  logic [HDR_W-1:0] hdr,
    output vkind_e           kind,
    output ur_info_t         info
);
    logic [DW_W-1:0] dw0;
    logic [DW_W-1:0] dw1;

    assign dw0 = hdr[0 +: DW_W];
    assign dw1 = hdr[DW_W +: DW_W];

    always_comb begin
        kind        = decode_kind(dw0, dw1, CODE_T0, CODE_T1);
        info.req_id = dw1[DW_W-1 -: RID_W];
        info.tag    = dw1[DW_W-RID_W-1 -: TAG_W];
    end
endmodule

// File: rtl/vmsg_hdr_bank.sv
module vmsg_hdr_bank
    import vmsg_pkg::*;
#(
    parameter int  NUM_DW = 4,
    localparam int HDR_W  = NUM_DW * DW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [HDR_W-1:0] din,
    output logic [HDR_W-1:0] dout
);
    genvar g;
    generate
        for (g = 0; g < NUM_DW; g++) begin : g_dw
            logic [DW_W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst)       word_q <= '0;
                else if (load) word_q <= din[g*DW_W +: DW_W];
            end
            assign dout[g*DW_W +: DW_W] = word_q;
        end
    endgenerate
endmodule

// File: rtl/vmsg_status.sv
module vmsg_status
    import vmsg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     beat_valid,
    input  vkind_e   kind,
    input  ur_info_t info_in,
    input  logic     mask,
    input  logic     clr,
    output logic     ready,
    output logic     capture,
    output logic     rcvd,
    output logic     ur_valid,
    output ur_info_t ur_info
);
    logic is_vendor;
    logic accept;
    logic reject_t0;

    always_comb begin
        is_vendor = (kind != VK_OTHER);
        ready     = !(is_vendor && rcvd && !mask);
        accept    = beat_valid && ready;
        capture   = accept && is_vendor && !mask;
        reject_t0 = accept && (kind == VK_T0) && mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rcvd     <= 1'b0;
            ur_valid <= 1'b0;
            ur_info  <= '0;
        end else begin
            // a new capture takes precedence over a clear in the same cycle
            rcvd     <= capture | (rcvd & ~clr);
            ur_valid <= reject_t0;
            if (reject_t0) ur_info <= info_in;
        end
    end
endmodule

// File: rtl/vmsg_capture.sv
module vmsg_capture
    import vmsg_pkg::*;
#(
    parameter int                NUM_DW  = 4,
    parameter logic [CODE_W-1:0] CODE_T0 = 8'h7E,
    parameter logic [CODE_W-1:0] CODE_T1 = 8'h7F,
    localparam int               HDR_W   = NUM_DW * DW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [HDR_W-1:0] in_hdr,
    input  logic             mask_i,
    input  logic             sts_clr_i,
    output logic             rcvd_o,
    output logic [HDR_W-1:0] hdr_regs_o,
    output logic             ur_valid_o,
    output logic [RID_W-1:0] ur_req_id_o,
    output logic [TAG_W-1:0] ur_tag_o
);
    vkind_e   kind;
    ur_info_t info_in;
    ur_info_t info_q;
    logic     capture;

    vmsg_classify #(
        .NUM_DW (NUM_DW),
        .CODE_T0(CODE_T0),
        .CODE_T1(CODE_T1)
    ) u_cls (
        .hdr (in_hdr),
        .kind(kind),
        .info(info_in)
    );

    vmsg_status u_sts (
        .clk       (clk),
        .rst       (rst),
        .beat_valid(in_valid),
        .kind      (kind),
        .info_in   (info_in),
        .mask      (mask_i),
        .clr       (sts_clr_i),
        .ready     (in_ready),
        .capture   (capture),
        .rcvd      (rcvd_o),
        .ur_valid  (ur_valid_o),
        .ur_info   (info_q)
    );

    vmsg_hdr_bank #(.NUM_DW(NUM_DW)) u_bank (
        .clk (clk),
        .rst (rst),
        .load(capture),
        .din (in_hdr),
        .dout(hdr_regs_o)
    );

    assign ur_req_id_o = info_q.req_id;
    assign ur_tag_o    = info_q.tag;
endmodule

// File: rtl/vmsg_capture_chk.sv
module vmsg_capture_chk #(
    parameter int HDR_W = 128
) (
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic             in_ready,
    input logic             mask_i,
    input logic             sts_clr_i,
    input logic             rcvd_o,
    input logic             ur_valid_o,
    input logic [HDR_W-1:0] hdr_regs_o
);
    AST_HOLD_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ready) |-> (rcvd_o && !mask_i)); // R6

    AST_HDR_FROZEN_WHILE_SET: assert property (@(posedge clk) disable iff (rst)
        (rcvd_o && $past(rcvd_o)) |-> $stable(hdr_regs_o)); // R1

    AST_SET_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        $rose(rcvd_o) |-> $past(in_valid && in_ready && !mask_i)); // R5

    AST_UR_ONLY_MASKED: assert property (@(posedge clk) disable iff (rst)
        ur_valid_o |-> $past(mask_i && in_valid && in_ready)); // R7

    AST_CLEAR_OBEYED: assert property (@(posedge clk) disable iff (rst)
        ($past(sts_clr_i) && rcvd_o) |-> $past(in_valid && in_ready)); // R9
endmodule

bind vmsg_capture vmsg_capture_chk #(.HDR_W(HDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .mask_i    (mask_i),
    .sts_clr_i (sts_clr_i),
    .rcvd_o    (rcvd_o),
    .ur_valid_o(ur_valid_o),
    .hdr_regs_o(hdr_regs_o)
);

// File: tb/tb_vmsg_capture.sv
`timescale 1ns/1ps
module tb_vmsg_capture;
    localparam int NUM_DW = 4;
    localparam int HDR_W  = NUM_DW * 32;

    logic             clk = 1'b0;
    logic             rst;
    logic             in_valid;
    logic             in_ready;
    logic [HDR_W-1:0] in_hdr;
    logic             mask_i;
    logic             sts_clr_i;
    logic             rcvd_o;
    logic [HDR_W-1:0] hdr_regs_o;
    logic             ur_valid_o;
    logic [15:0]      ur_req_id_o;
    logic [7:0]       ur_tag_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    vmsg_capture dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_hdr(in_hdr), .mask_i(mask_i), .sts_clr_i(sts_clr_i),
        .rcvd_o(rcvd_o), .hdr_regs_o(hdr_regs_o), .ur_valid_o(ur_valid_o),
        .ur_req_id_o(ur_req_id_o), .ur_tag_o(ur_tag_o)
    );

    task automatic chk(input bit ok, input string req, input logic [HDR_W-1:0] act,
                       input logic [HDR_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // DW0 Fmt/Type byte: 0x30 has Type[4:3]=2'b10; 0x00 does not
    function automatic logic [HDR_W-1:0] mk(input logic [7:0] fmt_type, input logic [7:0] code,
                                            input logic [15:0] rid, input logic [7:0] tag,
                                            input logic [31:0] dw2, input logic [31:0] dw3);
        logic [31:0] dw0;
        logic [31:0] dw1;
        dw0 = {fmt_type, 8'h00, 16'h0001};
        dw1 = {rid, tag, code};
        return {dw3, dw2, dw1, dw0};
    endfunction

    task automatic beat(input logic [HDR_W-1:0] h);
        @(negedge clk);
        in_valid = 1'b1;
        in_hdr   = h;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        sts_clr_i = 1'b1;
        @(negedge clk);
        sts_clr_i = 1'b0;
    endtask

    task automatic t_reset();
        chk(hdr_regs_o == '0, "R3 hdr", hdr_regs_o, '0);
        chk(rcvd_o == 1'b0, "R3 rcvd", HDR_W'(rcvd_o), 0);
        chk(ur_valid_o == 1'b0, "R3 ur", HDR_W'(ur_valid_o), 0);
        chk(in_ready == 1'b1, "R3 ready", HDR_W'(in_ready), 1);
    endtask

    task automatic t_capture();
        logic [HDR_W-1:0] h;
        h = mk(8'h30, 8'h7E, 16'h1234, 8'h56, 32'hA1B2C3D4, 32'h0BADF00D);
        beat(h);
        chk(hdr_regs_o == h, "R1 capture", hdr_regs_o, h);
        chk(hdr_regs_o[95:64] == 32'hA1B2C3D4, "R2 byte order dw2", hdr_regs_o[95:64], 32'hA1B2C3D4);
        chk(hdr_regs_o[63:56] == 8'h12, "R2 byte4 msb", hdr_regs_o[63:56], 8'h12);
        chk(rcvd_o == 1'b1, "R5 set", HDR_W'(rcvd_o), 1);
    endtask

    task automatic t_hold_and_clear();
        logic [HDR_W-1:0] h1;
        logic [HDR_W-1:0] h0;
        logic [HDR_W-1:0] oth;
        h0  = hdr_regs_o;
        h1  = mk(8'h34, 8'h7F, 16'hCAFE, 8'h11, 32'h22223333, 32'h44445555);
        oth = mk(8'h40, 8'h00, 16'h9999, 8'h99, 32'h1, 32'h2);
        // a non-vendor beat is still taken while full
        @(negedge clk);
        in_valid = 1'b1; in_hdr = oth;
        #1 chk(in_ready == 1'b1, "R6 non-vendor ready", HDR_W'(in_ready), 1);
        @(negedge clk);
        chk(hdr_regs_o == h0, "R4 non-vendor ignored", hdr_regs_o, h0);
        in_hdr = h1;
        #1 chk(in_ready == 1'b0, "R6 held", HDR_W'(in_ready), 0);
        repeat (3) @(negedge clk);
        chk(hdr_regs_o == h0, "R6 held no capture", hdr_regs_o, h0);
        sts_clr_i = 1'b1;
        @(negedge clk);
        sts_clr_i = 1'b0;
        // the clear landed on the previous edge; the held message is taken on the next one
        chk(rcvd_o == 1'b0, "R9 cleared", HDR_W'(rcvd_o), 0);
        chk(in_ready == 1'b1, "R9 ready after clear", HDR_W'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(hdr_regs_o == h1, "R9 held captured", hdr_regs_o, h1);
        chk(rcvd_o == 1'b1, "R5 set again", HDR_W'(rcvd_o), 1);
    endtask

    task automatic t_clear_with_capture();
        logic [HDR_W-1:0] h;
        clear_flag();
        h = mk(8'h30, 8'h7E, 16'h0F0F, 8'h33, 32'h5, 32'h6);
        @(negedge clk);
        in_valid = 1'b1; in_hdr = h; sts_clr_i = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; sts_clr_i = 1'b0;
        chk(rcvd_o == 1'b1, "R9 set wins", HDR_W'(rcvd_o), 1);
        chk(hdr_regs_o == h, "R9 new header kept", hdr_regs_o, h);
    endtask

    task automatic t_mask_t0();
        logic [HDR_W-1:0] h0;
        clear_flag();
        h0 = hdr_regs_o;
        mask_i = 1'b1;
        beat(mk(8'h30, 8'h7E, 16'hBEEF, 8'h5A, 32'h7, 32'h8));
        chk(ur_valid_o == 1'b1, "R7 ur pulse", HDR_W'(ur_valid_o), 1);
        chk(ur_req_id_o == 16'hBEEF, "R7 req id", HDR_W'(ur_req_id_o), 16'hBEEF);
        chk(ur_tag_o == 8'h5A, "R7 tag", HDR_W'(ur_tag_o), 8'h5A);
        chk(hdr_regs_o == h0, "R7 no capture", hdr_regs_o, h0);
        chk(rcvd_o == 1'b0, "R7 no status", HDR_W'(rcvd_o), 0);
        @(negedge clk);
        chk(ur_valid_o == 1'b0, "R7 one cycle", HDR_W'(ur_valid_o), 0);
        mask_i = 1'b0;
    endtask

    task automatic t_mask_t1();
        logic [HDR_W-1:0] h0;
        h0 = hdr_regs_o;
        mask_i = 1'b1;
        beat(mk(8'h30, 8'h7F, 16'h4321, 8'h77, 32'h9, 32'hA));
        chk(ur_valid_o == 1'b0, "R8 no ur", HDR_W'(ur_valid_o), 0);
        chk(hdr_regs_o == h0, "R8 no capture", hdr_regs_o, h0);
        chk(rcvd_o == 1'b0, "R8 no status", HDR_W'(rcvd_o), 0);
        mask_i = 1'b0;
    endtask

    task automatic t_near_miss();
        logic [HDR_W-1:0] h0;
        h0 = hdr_regs_o;
        beat(mk(8'h00, 8'h7E, 16'h1, 8'h1, 32'h1, 32'h1));
        chk(rcvd_o == 1'b0 && hdr_regs_o == h0, "R4 wrong type group", hdr_regs_o, h0);
        beat(mk(8'h30, 8'h7D, 16'h1, 8'h1, 32'h1, 32'h1));
        chk(rcvd_o == 1'b0 && hdr_regs_o == h0, "R4 wrong code", hdr_regs_o, h0);
        mask_i = 1'b1;
        beat(mk(8'h30, 8'h80, 16'h1, 8'h1, 32'h1, 32'h1));
        chk(ur_valid_o == 1'b0, "R4 masked non-vendor no ur", HDR_W'(ur_valid_o), 0);
        mask_i = 1'b0;
    endtask

    task automatic t_mask_release();
        logic [HDR_W-1:0] h0;
        beat(mk(8'h30, 8'h7F, 16'h2, 8'h2, 32'h3, 32'h4));
        h0 = hdr_regs_o;
        chk(rcvd_o == 1'b1, "R10 full", HDR_W'(rcvd_o), 1);
        @(negedge clk);
        in_valid = 1'b1;
        in_hdr   = mk(8'h30, 8'h7E, 16'hD00D, 8'hC3, 32'h5, 32'h6);
        #1 chk(in_ready == 1'b0, "R10 held", HDR_W'(in_ready), 0);
        mask_i = 1'b1;
        #1 chk(in_ready == 1'b1, "R10 released same cycle", HDR_W'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(ur_valid_o == 1'b1 && ur_req_id_o == 16'hD00D, "R10 released as ur",
            HDR_W'(ur_req_id_o), 16'hD00D);
        chk(hdr_regs_o == h0, "R10 no capture", hdr_regs_o, h0);
        mask_i = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_hdr = '0; mask_i = 1'b0; sts_clr_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_capture();
        t_hold_and_clear();
        t_clear_with_capture();
        t_mask_t0();
        t_mask_t1();
        t_near_miss();
        t_mask_release();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule